// File: doc/BRIEF.md
# UART Modem-Control Loopback

This block holds the control word of a UART and implements its internal loopback mode. A single control bit selects loopback. While it is set, the software-driven modem-control outputs in the control word are reflected straight back onto the modem-status flags. Every character the transmitter accepts is also pushed into the receive FIFO. A request to start sending break places a break entry in the receive path. The external receive data and external break events are blocked.

With loopback clear, the modem-status flags come from four external pins, each passed through a two-flop synchroniser. External receive characters and break events go through to the receive FIFO push port. The modem interrupt status bits are loaded from the looped levels on each control write that has loopback set, and they hold their value at all other times. Baud timing, the transmit line and the FIFO storage are outside this block. It only produces one push per cycle toward the receive FIFO.

Top module: `uart_modem_loopback`

## Requirements
- R1: After reset the control word reads 0x0300, the modem flags and modem interrupt bits are zero, and no receive push is issued; a control write is visible on `ctrlReg` after the next clock edge.
- R2: With control bit 7 set, the flag outputs follow the control word: flag bit 8 (ring) follows control bit 13, flag bit 2 (carrier) follows bit 12, flag bit 0 (clear-to-send) follows bit 11, flag bit 1 (data-set-ready) follows bit 10, and flag bits 7..3 are zero. This holds in the cycle after the write, including the write that first sets bit 7.
- R3: Every control write with bit 7 set loads the modem interrupt bits from the looped levels: bit 0 ring, bit 1 clear-to-send, bit 2 carrier, bit 3 data-set-ready. Control writes with bit 7 clear leave the modem interrupt bits unchanged.
- R4: With control bit 7 clear, the flag outputs take the four modem pins through two flip-flops. A pin change is not visible after one clock edge and is visible after two.
- R5: With loopback on, a transmit strobe produces a receive push in the following cycle carrying the character in bits 7..0, with bits 10..8 zero.
- R6: Every transmit strobe pulses `txIntSet` for one cycle in the following cycle, whether loopback is on or off.
- R7: With loopback on, a 0-to-1 transition of the break request produces exactly one receive push of 0x400 (only bit 10 set). Holding the request high, or dropping it, produces none. With loopback off, the break request produces no push.
- R8: With loopback on, external receive characters and external break events produce no receive push.
- R9: With loopback off, an external character is pushed with bits 10..8 zero, an external break event is pushed as 0x400, and a transmit strobe causes no push.
- R10: When a character and a break entry fall due in the same cycle, the character is pushed first and the break entry in the next free cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 16 | Control word write value |
| ctrlReg | output | 16 | Current control word |
| txStrobe | input | 1 | Transmitter accepts a character |
| txData | input | 8 | Character being transmitted |
| brkReq | input | 1 | Break request level from the line control |
| extRxValid | input | 1 | External receiver has a character |
| extRxData | input | 8 | External received character |
| extBreak | input | 1 | External receiver detected a break |
| ringIn | input | 1 | Ring indicator pin |
| carrierIn | input | 1 | Carrier detect pin |
| dataSetIn | input | 1 | Data-set-ready pin |
| clearIn | input | 1 | Clear-to-send pin |
| modemFlags | output | 9 | Modem-status flag bits (8 ring, 2 carrier, 1 data-set-ready, 0 clear-to-send) |
| modemInt | output | 4 | Modem interrupt status (0 ring, 1 clear-to-send, 2 carrier, 3 data-set-ready) |
| txIntSet | output | 1 | One-cycle request to set the transmit interrupt |
| rxPushValid | output | 1 | Receive FIFO push strobe |
| rxPushData | output | 11 | Receive FIFO entry (bit 10 break, bits 7..0 character) |

## Verification
The hardest case to reach from the ports is a loopback break edge that lands in the same cycle as a transmit character. The break entry then has to wait in the pending register and come out one cycle after the character. The bench raises the break request and the transmit strobe on the same falling edge and samples the push port on the two following cycles. It also holds the break request high to show that a level produces no second entry. It toggles loopback around pin changes to separate the looped flags from the synchronised ones.

// File: rtl/lb_pkg.sv
package lb_pkg;
  localparam int CTRL_W   = 16;
  localparam int DATA_W   = 8;
  localparam int BRK_BIT  = 10;
  localparam int ENTRY_W  = BRK_BIT + 1;
  localparam int FLAG_W   = 9;
  localparam int MODEM_N  = 4;

  // Control word positions (behaviour depends on these)
  localparam int LOOP_BIT = 7;
  localparam int DTR_BIT  = 10;
  localparam int RTS_BIT  = 11;
  localparam int OUT1_BIT = 12;
  localparam int OUT2_BIT = 13;

  // Flag positions
  localparam int F_RI  = 8;
  localparam int F_DCD = 2;
  localparam int F_DSR = 1;
  localparam int F_CTS = 0;

  // Modem-level vector order used internally: {ri, dcd, dsr, cts}
  localparam int L_RI  = 3;
  localparam int L_DCD = 2;
  localparam int L_DSR = 1;
  localparam int L_CTS = 0;

  localparam logic [ENTRY_W-1:0] BRK_ENTRY = ENTRY_W'(1) << BRK_BIT;

  typedef struct packed {
    logic loopOn;
    logic pushData;
    logic pushBreak;
    logic selTx;
  } lbStrobe_t;

  // Looped levels taken from a control value, in {ri, dcd, dsr, cts} order
  function automatic logic [MODEM_N-1:0] loopLevels(input logic [CTRL_W-1:0] c);
    return {c[OUT2_BIT], c[OUT1_BIT], c[DTR_BIT], c[RTS_BIT]};
  endfunction

  // Interrupt bit order: 0 ri, 1 cts, 2 dcd, 3 dsr
  function automatic logic [MODEM_N-1:0] levelsToInt(input logic [MODEM_N-1:0] l);
    return {l[L_DSR], l[L_DCD], l[L_CTS], l[L_RI]};
  endfunction
endpackage

// File: rtl/lb_control.sv
module lb_control
  import lb_pkg::*;
#(
  parameter logic [CTRL_W-1:0] CTRL_RESET = 16'h0300
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              txStrobe,
  input  logic              brkReq,
  input  logic              extRxValid,
  input  logic              extBreak,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic [MODEM_N-1:0] modemLoop,
  output logic [MODEM_N-1:0] modemInt,
  output lbStrobe_t         strb
);
  logic loopOn;
  logic brkPrev;
  logic pendBrk;
  logic dataReq;
  logic newBrk;
  logic brkWant;

  assign loopOn    = ctrlReg[LOOP_BIT];
  assign modemLoop = loopLevels(ctrlReg);

  always_comb begin
    dataReq = loopOn ? txStrobe : extRxValid;
    newBrk  = loopOn ? (brkReq & ~brkPrev) : extBreak;
    brkWant = pendBrk | newBrk;
    strb.loopOn    = loopOn;
    strb.selTx     = loopOn;
    strb.pushData  = dataReq;
    strb.pushBreak = brkWant & ~dataReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= CTRL_RESET;
      modemInt <= '0;
      brkPrev  <= 1'b0;
      pendBrk  <= 1'b0;
    end else begin
      if (ctrlWrEn) begin
        ctrlReg <= ctrlWrData;
        if (ctrlWrData[LOOP_BIT])
          modemInt <= levelsToInt(loopLevels(ctrlWrData));
      end
      brkPrev <= brkReq;
      pendBrk <= brkWant & dataReq;
    end
  end

  // R3: interrupt bits agree with the looped levels after a loopback write
  a_r3_int_tracks_loop: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && ctrlWrData[LOOP_BIT]) |=>
      (modemInt[0] == modemLoop[L_RI]) && (modemInt[1] == modemLoop[L_CTS]) &&
      (modemInt[2] == modemLoop[L_DCD]) && (modemInt[3] == modemLoop[L_DSR]));

  // R3: writes without loopback leave interrupt bits alone
  a_r3_int_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && !ctrlWrData[LOOP_BIT]) |=> $stable(modemInt));

  // R8: external characters never reach the push path in loopback
  a_r8_ext_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (loopOn && extRxValid && !txStrobe) |-> !strb.pushData);
endmodule

// File: rtl/lb_datapath.sv
module lb_datapath
  import lb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  lbStrobe_t          strb,
  input  logic [MODEM_N-1:0] modemLoop,
  input  logic [MODEM_N-1:0] modemPins,
  input  logic               txStrobe,
  input  logic [DATA_W-1:0]  txData,
  input  logic [DATA_W-1:0]  extRxData,
  output logic [FLAG_W-1:0]  modemFlags,
  output logic               txIntSet,
  output logic               rxPushValid,
  output logic [ENTRY_W-1:0] rxPushData
);
  localparam int PAD_W = ENTRY_W - DATA_W;

  logic [MODEM_N-1:0] syncStage [SYNC_STAGES];
  logic [MODEM_N-1:0] pinLevels;
  logic [MODEM_N-1:0] levels;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncStage[s] <= '0;
      else if (s == 0) syncStage[s] <= modemPins;
      else syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
    end
  end

  assign pinLevels = syncStage[SYNC_STAGES-1];
  assign levels    = strb.loopOn ? modemLoop : pinLevels;

  always_comb begin
    modemFlags        = '0;
    modemFlags[F_RI]  = levels[L_RI];
    modemFlags[F_DCD] = levels[L_DCD];
    modemFlags[F_DSR] = levels[L_DSR];
    modemFlags[F_CTS] = levels[L_CTS];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxPushValid <= 1'b0;
      rxPushData  <= '0;
      txIntSet    <= 1'b0;
    end else begin
      txIntSet <= txStrobe;
      if (strb.pushData) begin
        rxPushValid <= 1'b1;
        rxPushData  <= {{PAD_W{1'b0}}, (strb.selTx ? txData : extRxData)};
      end else if (strb.pushBreak) begin
        rxPushValid <= 1'b1;
        rxPushData  <= BRK_ENTRY;
      end else begin
        rxPushValid <= 1'b0;
      end
    end
  end

  // R5: looped character appears on the push port one cycle later
  a_r5_tx_copy: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pushData && strb.selTx) |=>
      rxPushValid && (rxPushData == {{PAD_W{1'b0}}, $past(txData)}));

  // R7: a break entry carries no character bits
  a_r7_break_word: assert property (@(posedge clk) disable iff (!rstN)
    (rxPushValid && rxPushData[BRK_BIT]) |-> (rxPushData[DATA_W-1:0] == '0));

  // R6: transmit interrupt request follows every strobe
  a_r6_tx_int: assert property (@(posedge clk) disable iff (!rstN)
    txStrobe |=> txIntSet);
endmodule

// File: rtl/uart_modem_loopback.sv
module uart_modem_loopback
  import lb_pkg::*;
#(
  parameter logic [CTRL_W-1:0] CTRL_RESET  = 16'h0300,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWrEn,
  input  logic [CTRL_W-1:0]   ctrlWrData,
  output logic [CTRL_W-1:0]   ctrlReg,
  input  logic                txStrobe,
  input  logic [DATA_W-1:0]   txData,
  input  logic                brkReq,
  input  logic                extRxValid,
  input  logic [DATA_W-1:0]   extRxData,
  input  logic                extBreak,
  input  logic                ringIn,
  input  logic                carrierIn,
  input  logic                dataSetIn,
  input  logic                clearIn,
  output logic [FLAG_W-1:0]   modemFlags,
  output logic [MODEM_N-1:0]  modemInt,
  output logic                txIntSet,
  output logic                rxPushValid,
  output logic [ENTRY_W-1:0]  rxPushData
);
  lbStrobe_t          strb;
  logic [MODEM_N-1:0] modemLoop;

  lb_control #(.CTRL_RESET(CTRL_RESET)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlWrData (ctrlWrData),
    .txStrobe   (txStrobe),
    .brkReq     (brkReq),
    .extRxValid (extRxValid),
    .extBreak   (extBreak),
    .ctrlReg    (ctrlReg),
    .modemLoop  (modemLoop),
    .modemInt   (modemInt),
    .strb       (strb)
  );

  lb_datapath #(.SYNC_STAGES(SYNC_STAGES)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .modemLoop   (modemLoop),
    .modemPins   ({ringIn, carrierIn, dataSetIn, clearIn}),
    .txStrobe    (txStrobe),
    .txData      (txData),
    .extRxData   (extRxData),
    .modemFlags  (modemFlags),
    .txIntSet    (txIntSet),
    .rxPushValid (rxPushValid),
    .rxPushData  (rxPushData)
  );
endmodule

// File: tb/uart_modem_loopback_test.sv
`timescale 1ns/1ps
module uart_modem_loopback_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWrEn = 1'b0;
  logic [15:0] ctrlWrData = '0;
  logic [15:0] ctrlReg;
  logic        txStrobe = 1'b0;
  logic [7:0]  txData = '0;
  logic        brkReq = 1'b0;
  logic        extRxValid = 1'b0;
  logic [7:0]  extRxData = '0;
  logic        extBreak = 1'b0;
  logic        ringIn = 1'b0, carrierIn = 1'b0, dataSetIn = 1'b0, clearIn = 1'b0;
  logic [8:0]  modemFlags;
  logic [3:0]  modemInt;
  logic        txIntSet;
  logic        rxPushValid;
  logic [10:0] rxPushData;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  uart_modem_loopback uut (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .ctrlReg(ctrlReg), .txStrobe(txStrobe), .txData(txData), .brkReq(brkReq),
    .extRxValid(extRxValid), .extRxData(extRxData), .extBreak(extBreak),
    .ringIn(ringIn), .carrierIn(carrierIn), .dataSetIn(dataSetIn), .clearIn(clearIn),
    .modemFlags(modemFlags), .modemInt(modemInt), .txIntSet(txIntSet),
    .rxPushValid(rxPushValid), .rxPushData(rxPushData)
  );

  // {control value, expected flags, expected interrupt bits}; pins held at ri0 dcd1 dsr0 cts1
  localparam logic [28:0] VEC [10] = '{
    {16'h0080, 9'h000, 4'h0},
    {16'h2080, 9'h100, 4'h1},
    {16'h1080, 9'h004, 4'h4},
    {16'h0880, 9'h001, 4'h2},
    {16'h0480, 9'h002, 4'h8},
    {16'h3C80, 9'h107, 4'hF},
    {16'h3C00, 9'h005, 4'hF},
    {16'h0000, 9'h005, 4'hF},
    {16'h0080, 9'h000, 4'h0},
    {16'h2480, 9'h102, 4'h9}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  task automatic ctrlWrite(input logic [15:0] v);
    @(negedge clk);
    ctrlWrEn = 1'b1; ctrlWrData = v;
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ctrl reset", 32'(ctrlReg), 32'h0300);
    chk("R1 flags reset", 32'(modemFlags), 32'h0);
    chk("R1 int reset", 32'(modemInt), 32'h0);
    chk("R1 no push at reset", 32'(rxPushValid), 32'h0);

    {ringIn, carrierIn, dataSetIn, clearIn} = 4'b0101;
    repeat (3) @(negedge clk);

    // Vector walk: R1 readback, R2 looped flags, R3 interrupt load and hold, R4 pin flags
    foreach (VEC[i]) begin
      ctrlWrite(VEC[i][28:13]);
      chk($sformatf("R1 ctrl readback row %0d", i), 32'(ctrlReg), 32'(VEC[i][28:13]));
      chk($sformatf("R2/R4 flags row %0d", i), 32'(modemFlags), 32'(VEC[i][12:4]));
      chk($sformatf("R3 int row %0d", i), 32'(modemInt), 32'(VEC[i][3:0]));
    end

    // R5, R6: looped character
    @(negedge clk); txStrobe = 1'b1; txData = 8'h5A;
    @(negedge clk); txStrobe = 1'b0;
    chk("R5 loop push valid", 32'(rxPushValid), 32'h1);
    chk("R5 loop push data", 32'(rxPushData), 32'h05A);
    chk("R6 tx int in loopback", 32'(txIntSet), 32'h1);
    @(negedge clk);
    chk("R6 tx int one cycle", 32'(txIntSet), 32'h0);

    // R8: external input blocked in loopback
    extRxValid = 1'b1; extRxData = 8'h33;
    @(negedge clk); extRxValid = 1'b0; extBreak = 1'b1;
    chk("R8 ext char blocked", 32'(rxPushValid), 32'h0);
    @(negedge clk); extBreak = 1'b0;
    chk("R8 ext break blocked", 32'(rxPushValid), 32'h0);

    // R7: break edge in loopback
    @(negedge clk); brkReq = 1'b1;
    @(negedge clk);
    chk("R7 break push valid", 32'(rxPushValid), 32'h1);
    chk("R7 break entry", 32'(rxPushData), 32'h400);
    @(negedge clk);
    chk("R7 held level no push", 32'(rxPushValid), 32'h0);
    brkReq = 1'b0;
    @(negedge clk);
    chk("R7 falling no push", 32'(rxPushValid), 32'h0);

    // R10: break edge and character in the same cycle
    brkReq = 1'b1; txStrobe = 1'b1; txData = 8'hC3;
    @(negedge clk); txStrobe = 1'b0;
    chk("R10 char first", 32'({rxPushValid, rxPushData}), 32'h8C3);
    @(negedge clk);
    chk("R10 break next", 32'({rxPushValid, rxPushData}), 32'hC00);
    @(negedge clk);
    chk("R10 single break", 32'(rxPushValid), 32'h0);
    brkReq = 1'b0;

    // Loopback off
    ctrlWrite(16'h0000);
    brkReq = 1'b1;
    @(negedge clk);
    chk("R7 break ignored when off", 32'(rxPushValid), 32'h0);
    brkReq = 1'b0;
    txStrobe = 1'b1; txData = 8'h11;
    @(negedge clk); txStrobe = 1'b0;
    chk("R9 tx not pushed when off", 32'(rxPushValid), 32'h0);
    chk("R6 tx int when off", 32'(txIntSet), 32'h1);
    extRxValid = 1'b1; extRxData = 8'h33;
    @(negedge clk); extRxValid = 1'b0;
    chk("R9 ext char pushed", 32'({rxPushValid, rxPushData}), 32'h833);
    extBreak = 1'b1;
    @(negedge clk); extBreak = 1'b0;
    chk("R9 ext break pushed", 32'({rxPushValid, rxPushData}), 32'hC00);

    // R4: two-flop latency on pin change
    {ringIn, carrierIn, dataSetIn, clearIn} = 4'b1010;
    @(negedge clk);
    chk("R4 not after one edge", 32'(modemFlags), 32'h005);
    @(negedge clk);
    chk("R4 visible after two edges", 32'(modemFlags), 32'h102);
    chk("R3 int held while off", 32'(modemInt), 32'h9);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule